// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small multicycle processor built around a single 16-bit accumulator. It reads its program and its data through one synchronous memory port. The port has an address, write data, read data that arrives one cycle after the address, and a write enable. Each 16-bit instruction holds a 4-bit operation code in its top bits and a 12-bit operand below it. For memory-reference instructions the operand is a direct memory address. For register-reference instructions it names one of eight general registers. For jumps it is the target address.

Load, store, add and subtract each come in two forms, one for memory and one for a register. The two forms share the low three opcode bits and differ only in the opcode's top bit. Increment and decrement act on a general register through a dedicated up/down counter and never disturb the accumulator. The remaining instructions are an unconditional jump, two jumps that test the zero flag, and a halt. The program counter, the accumulator, the zero flag and a halted indication are visible at the ports.

Every instruction passes through fetch, decode and execute. Memory loads and arithmetic take one extra write-back cycle so that the operand can return from memory.

Top module: `acc_core`

## Requirements
- R1: Reset (active-low, asynchronous) clears the program counter, accumulator, zero flag, halted indication and all eight general registers to zero.
- R2: Opcode 0x1 loads the accumulator from the memory word at the 12-bit address. Opcode 0x2 writes the accumulator to that address.
- R3: Opcode 0x5 adds and opcode 0x4 subtracts the addressed memory word to or from the accumulator, modulo 2^16 (for example 10 − 5 leaves 5).
- R4: Setting the top opcode bit selects the register form, with the register given by operand bits [2:0]: 0x9 loads Rn into the accumulator, 0xA stores the accumulator to Rn, 0xD adds Rn and 0xC subtracts Rn.
- R5: Opcode 0xE increments and opcode 0xF decrements Rn (operand bits [2:0]) by one, modulo 2^16, and leave the accumulator unchanged.
- R6: The zero flag takes the zero test of the result of every load into the accumulator, add, subtract, increment and decrement. Stores and jumps leave the flag unchanged.
- R7: Opcode 0x0 loads the program counter with the 12-bit operand.
- R8: Opcode 0x3 jumps to the operand when the zero flag is set. Opcode 0x6 jumps when the flag is clear. Otherwise execution falls through.
- R9: Opcode 0x8 enters a halted state that lasts until reset. In that state halted is 1, the program counter reads the halt instruction's address plus one, and no state changes.
- R10: Opcodes 0x7 and 0xB execute as no-operations.
- R11: During fetch the memory address equals the program counter. Write enable is asserted only while a memory store executes, exactly once per store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Store data (the accumulator) |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write enable |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |
| zero_flag | output | 1 | Zero test of the last flag-writing result |
| halted | output | 1 | High while halted |

## Verification
Two paths can land in the same execute cycle and must stay apart. One is the counter path, which writes a general register and the zero flag. The other is the accumulator, which that same cycle must leave alone. The bench provokes this by loading zero into the accumulator and then incrementing a register. A correct core shows the accumulator still at zero and the flag cleared by the counter result. A second pairing is a flag write followed straight away by a conditional jump. Each jump kind is run with the flag both set and clear, and the final accumulator shows whether the fall-through load was executed.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   localparam int OPC_W = 4;

   // full opcode values
   localparam logic [3:0] OPC_JMP = 4'h0;
   localparam logic [3:0] OPC_JZ  = 4'h3;
   localparam logic [3:0] OPC_JNZ = 4'h6;
   localparam logic [3:0] OPC_HLT = 4'h8;
   localparam logic [3:0] OPC_INC = 4'hE;
   localparam logic [3:0] OPC_DEC = 4'hF;

   // low three bits shared by the memory and register forms
   localparam logic [2:0] BASE_LOAD  = 3'd1;
   localparam logic [2:0] BASE_STORE = 3'd2;
   localparam logic [2:0] BASE_SUB   = 3'd4;
   localparam logic [2:0] BASE_ADD   = 3'd5;

   typedef enum logic [1:0] {
      ALU_PASS = 2'd0,
      ALU_ADD  = 2'd1,
      ALU_SUB  = 2'd2
   } alu_op_e;

   typedef enum logic [1:0] {
      JC_ALWAYS  = 2'd0,
      JC_ZERO    = 2'd1,
      JC_NONZERO = 2'd2
   } jcond_e;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_WBACK  = 3'd3,
      ST_HALT   = 3'd4
   } state_e;

   typedef struct packed {
      logic    acc_wr;
      logic    src_reg;
      alu_op_e alu_op;
      logic    mem_wr;
      logic    reg_wr;
      logic    cnt_en;
      logic    cnt_down;
      logic    jump;
      jcond_e  jcond;
      logic    halt;
   } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_core_pkg::*;
#(
   parameter int OP_W = 4
) (
   input  logic [OP_W-1:0] opcode,
   output dec_t            dec
);

   if (OP_W != OPC_W) begin : g_bad_opw
      $error("acc_decode: OP_W must equal the package opcode width");
   end

   logic            reg_form;
   logic [OP_W-2:0] base;

   assign reg_form = opcode[OP_W-1];
   assign base     = opcode[OP_W-2:0];

   always_comb begin
      dec        = '0;
      dec.alu_op = ALU_PASS;
      dec.jcond  = JC_ALWAYS;
      case (opcode)
         OPC_JMP: dec.jump = 1'b1;
         OPC_JZ: begin
            dec.jump  = 1'b1;
            dec.jcond = JC_ZERO;
         end
         OPC_JNZ: begin
            dec.jump  = 1'b1;
            dec.jcond = JC_NONZERO;
         end
         OPC_HLT: dec.halt = 1'b1;
         OPC_INC: dec.cnt_en = 1'b1;
         OPC_DEC: begin
            dec.cnt_en   = 1'b1;
            dec.cnt_down = 1'b1;
         end
         default: begin
            // memory and register forms share the base code
            case (base)
               BASE_LOAD: begin
                  dec.acc_wr  = 1'b1;
                  dec.src_reg = reg_form;
                  dec.alu_op  = ALU_PASS;
               end
               BASE_STORE: begin
                  dec.mem_wr = !reg_form;
                  dec.reg_wr = reg_form;
               end
               BASE_SUB: begin
                  dec.acc_wr  = 1'b1;
                  dec.src_reg = reg_form;
                  dec.alu_op  = ALU_SUB;
               end
               BASE_ADD: begin
                  dec.acc_wr  = 1'b1;
                  dec.src_reg = reg_form;
                  dec.alu_op  = ALU_ADD;
               end
               default: ; // unassigned code: no operation
            endcase
         end
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_core_pkg::*;
#(
   parameter int DW            = 16,
   parameter bit SHARED_ADDER  = 1'b1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  alu_op_e       op,
   output logic [DW-1:0] res,
   output logic          zero
);

   logic [DW-1:0] arith;

   if (SHARED_ADDER) begin : g_shared
      // one carry chain: subtract as a + ~b + 1
      logic          is_sub;
      logic [DW-1:0] b_eff;
      assign is_sub = (op == ALU_SUB);
      assign b_eff  = is_sub ? ~b : b;
      assign arith  = a + b_eff + DW'(is_sub);
   end else begin : g_split
      logic [DW-1:0] sum;
      logic [DW-1:0] diff;
      assign sum   = a + b;
      assign diff  = a - b;
      assign arith = (op == ALU_SUB) ? diff : sum;
   end

   always_comb begin
      case (op)
         ALU_ADD, ALU_SUB: res = arith;
         default:          res = b;
      endcase
   end

   assign zero = (res == '0);

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
   parameter int DW   = 16,
   parameter int NREG = 8,
   localparam int SW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] sel,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          cnt_en,
   input  logic          cnt_down,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] cnt_val
);

   if ((1 << SW) != NREG) begin : g_bad_nreg
      $error("acc_regfile: NREG must be a power of two");
   end

   logic [DW-1:0] regs_q [NREG];

   assign rd_data = regs_q[sel];

   // up/down counter path, independent of the accumulator arithmetic
   assign cnt_val = cnt_down ? (rd_data - DW'(1)) : (rd_data + DW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (SW'(i) == sel) begin
               if (wr_en)       regs_q[i] <= wr_data;
               else if (cnt_en) regs_q[i] <= cnt_val;
            end
         end
      end
   end

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int OP_W         = 4,
   parameter int ADDR_W       = 12,
   parameter int NREG         = 8,
   parameter bit SHARED_ADDER = 1'b1,
   localparam int IW          = OP_W + ADDR_W,
   localparam int RSEL_W      = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] acc,
   output logic              zero_flag,
   output logic              halted
);

   if (DATA_W != IW) begin : g_bad_iw
      $error("acc_core: DATA_W must equal OP_W + ADDR_W");
   end
   if (RSEL_W > ADDR_W) begin : g_bad_rsel
      $error("acc_core: register select wider than operand");
   end

   state_e            state_q;
   logic [IW-1:0]     ir_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] acc_q;
   logic              z_q;

   logic [OP_W-1:0]   opcode;
   logic [ADDR_W-1:0] operand;
   logic [RSEL_W-1:0] rsel;
   dec_t              dec;
   logic              in_exec;
   logic              take_jump;

   logic [DATA_W-1:0] reg_rd;
   logic [DATA_W-1:0] cnt_val;
   logic [DATA_W-1:0] alu_b;
   logic [DATA_W-1:0] alu_res;
   logic              alu_zero;

   assign opcode  = ir_q[IW-1 -: OP_W];
   assign operand = ir_q[ADDR_W-1:0];
   assign rsel    = ir_q[RSEL_W-1:0];
   assign in_exec = (state_q == ST_EXEC);

   acc_decode #(.OP_W(OP_W)) u_dec (
      .opcode (opcode),
      .dec    (dec)
   );

   acc_regfile #(.DW(DATA_W), .NREG(NREG)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (rsel),
      .wr_en    (in_exec && dec.reg_wr),
      .wr_data  (acc_q),
      .cnt_en   (in_exec && dec.cnt_en),
      .cnt_down (dec.cnt_down),
      .rd_data  (reg_rd),
      .cnt_val  (cnt_val)
   );

   assign alu_b = dec.src_reg ? reg_rd : mem_rdata;

   acc_alu #(.DW(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .a    (acc_q),
      .b    (alu_b),
      .op   (dec.alu_op),
      .res  (alu_res),
      .zero (alu_zero)
   );

   always_comb begin
      case (dec.jcond)
         JC_ALWAYS:  take_jump = 1'b1;
         JC_ZERO:    take_jump = z_q;
         JC_NONZERO: take_jump = !z_q;
         default:    take_jump = 1'b0;
      endcase
   end

   // memory port
   assign mem_addr  = (state_q == ST_FETCH) ? pc_q : operand;
   assign mem_wdata = acc_q;
   assign mem_we    = in_exec && dec.mem_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         ir_q    <= '0;
         pc_q    <= '0;
         acc_q   <= '0;
         z_q     <= 1'b0;
      end else begin
         case (state_q)
            ST_FETCH: state_q <= ST_DECODE;
            ST_DECODE: begin
               ir_q    <= mem_rdata;
               pc_q    <= pc_q + ADDR_W'(1);
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               if (dec.halt) begin
                  state_q <= ST_HALT;
               end else if (dec.acc_wr && !dec.src_reg) begin
                  state_q <= ST_WBACK;
               end else begin
                  if (dec.acc_wr) begin
                     acc_q <= alu_res;
                     z_q   <= alu_zero;
                  end
                  if (dec.cnt_en) z_q <= (cnt_val == '0);
                  if (dec.jump && take_jump) pc_q <= operand;
                  state_q <= ST_FETCH;
               end
            end
            ST_WBACK: begin
               acc_q   <= alu_res;
               z_q     <= alu_zero;
               state_q <= ST_FETCH;
            end
            ST_HALT: state_q <= ST_HALT;
            default: state_q <= ST_FETCH;
         endcase
      end
   end

   assign pc        = pc_q;
   assign acc       = acc_q;
   assign zero_flag = z_q;
   assign halted    = (state_q == ST_HALT);

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
   import acc_core_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic [AW-1:0] pc,
   input logic [DW-1:0] acc,
   input logic          zero_flag,
   input logic          halted,
   input logic [2:0]    state,
   input logic [DW-1:0] ir
);

   logic [3:0] op;
   logic       exec;
   assign op   = ir[DW-1 -: 4];
   assign exec = (state == ST_EXEC);

   // R1
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (pc == '0 && acc == '0 && !zero_flag && !halted));

   // R9
   a_r9_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(pc) && $stable(acc) && $stable(zero_flag) && !mem_we));

   // R11
   a_r11_fetch_port: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH) |-> (mem_addr == pc && !mem_we));

   // R11
   a_r11_we_store_only: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (exec && op == 4'h2));

   // R5
   a_r5_acc_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && (op == 4'hE || op == 4'hF)) |=> $stable(acc));

   // R6
   a_r6_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && (op == 4'h2 || op == 4'hA || op == 4'h0 || op == 4'h3 || op == 4'h6))
      |=> $stable(zero_flag));

   // R7
   a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == 4'h0) |=> (pc == $past(ir[AW-1:0])));

   // R8
   a_r8_jz_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == 4'h3 && zero_flag) |=> (pc == $past(ir[AW-1:0])));

   // R8
   a_r8_jnz_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == 4'h6 && zero_flag) |=> $stable(pc));

endmodule

bind acc_core acc_core_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .pc        (pc),
   .acc       (acc),
   .zero_flag (zero_flag),
   .halted    (halted),
   .state     (state_q),
   .ir        (ir_q)
);

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;

   localparam int VW = 117;
   localparam int NV = 20;

   // {req, i0, i1, i2, d0 @0x80, d1 @0x81, exp acc, exp zero, exp pc}
   localparam logic [VW-1:0] VEC [NV] = '{
      {8'd3,  16'h1080, 16'h4081, 16'h7000, 16'h000A, 16'h0005, 16'h0005, 1'b0, 12'h004}, // R3 subtract
      {8'd3,  16'h1080, 16'h5081, 16'h7000, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 12'h004}, // R3 add wraps
      {8'd6,  16'h1080, 16'h7000, 16'h7000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 12'h004}, // R6 load zero
      {8'd4,  16'h1080, 16'hA003, 16'hD003, 16'h0007, 16'h0000, 16'h000E, 1'b0, 12'h004}, // R4 store/add reg
      {8'd4,  16'h1080, 16'hA002, 16'hC002, 16'h0003, 16'h0000, 16'h0000, 1'b1, 12'h004}, // R4 sub reg
      {8'd4,  16'h1080, 16'h9000, 16'h7000, 16'h0005, 16'h0000, 16'h0000, 1'b1, 12'h004}, // R4 load R0
      {8'd5,  16'h1080, 16'hE005, 16'h7000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 12'h004}, // R5 inc keeps acc
      {8'd5,  16'h1080, 16'hE005, 16'h9005, 16'h0003, 16'h0000, 16'h0001, 1'b0, 12'h004}, // R5 inc then read
      {8'd1,  16'h9005, 16'h7000, 16'h7000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 12'h004}, // R1 regs cleared
      {8'd5,  16'hF001, 16'h9001, 16'h7000, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 12'h004}, // R5 dec wraps
      {8'd5,  16'hE004, 16'hF004, 16'h7000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 12'h004}, // R5 dec to zero
      {8'd8,  16'h1080, 16'h3003, 16'h1081, 16'h0000, 16'h0055, 16'h0000, 1'b1, 12'h004}, // R8 JZ taken
      {8'd8,  16'h1080, 16'h3003, 16'h1081, 16'h0001, 16'h0055, 16'h0055, 1'b0, 12'h004}, // R8 JZ falls
      {8'd8,  16'h1080, 16'h6003, 16'h1081, 16'h0002, 16'h0055, 16'h0002, 1'b0, 12'h004}, // R8 JNZ taken
      {8'd8,  16'h1080, 16'h6003, 16'h1081, 16'h0000, 16'h0055, 16'h0055, 1'b0, 12'h004}, // R8 JNZ falls
      {8'd7,  16'h1080, 16'h0010, 16'h1081, 16'h0009, 16'h0055, 16'h0009, 1'b0, 12'h011}, // R7 far jump
      {8'd6,  16'h1080, 16'h2090, 16'h0003, 16'h0000, 16'h0000, 16'h0000, 1'b1, 12'h004}, // R6 store/jump keep flag
      {8'd10, 16'h1080, 16'hB000, 16'h7FFF, 16'h0004, 16'h0000, 16'h0004, 1'b0, 12'h004}, // R10 undefined codes
      {8'd2,  16'h1080, 16'h2090, 16'h1090, 16'h1234, 16'h0000, 16'h1234, 1'b0, 12'h004}, // R2 store then load
      {8'd9,  16'h8000, 16'h1080, 16'h1081, 16'h0007, 16'h0055, 16'h0000, 1'b0, 12'h001}  // R9 halt first
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        mem_we;
   logic [11:0] pc;
   logic [15:0] acc;
   logic        zero_flag;
   logic        halted;

   logic        ld_en = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [15:0] ld_data = '0;
   logic [15:0] mem [256];
   int          we_cnt;

   int tests  = 0;
   int failed = 0;

   always #4 clk = ~clk;

   acc_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_we    (mem_we),
      .pc        (pc),
      .acc       (acc),
      .zero_flag (zero_flag),
      .halted    (halted)
   );

   always @(posedge clk) begin
      if (ld_en) mem[ld_addr] <= ld_data;
      else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_cnt <= 0;
      else if (mem_we) we_cnt <= we_cnt + 1;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      ld_en   = 1'b1;
      ld_addr = a;
      ld_data = d;
   endtask

   task automatic run_vec(input int k);
      logic [VW-1:0] v;
      v = VEC[k];
      rst_n = 1'b0;
      for (int a = 0; a < 256; a++) put(8'(a), 16'h8000);
      put(8'h00, v[108:93]);
      put(8'h01, v[92:77]);
      put(8'h02, v[76:61]);
      put(8'h80, v[60:45]);
      put(8'h81, v[44:29]);
      @(negedge clk);
      ld_en = 1'b0;
      rst_n = 1'b1;
      for (int c = 0; c < 300 && !halted; c++) @(negedge clk);
      check($sformatf("R%0d vec%0d halted", v[116:109], k), 32'(halted), 32'd1);
      check($sformatf("R%0d vec%0d acc", v[116:109], k), 32'(acc), 32'(v[28:13]));
      check($sformatf("R%0d vec%0d zero", v[116:109], k), 32'(zero_flag), 32'(v[12]));
      check($sformatf("R%0d vec%0d pc", v[116:109], k), 32'(pc), 32'(v[11:0]));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failed++;
      $display("FAIL R9 watchdog actual=running expected=halted");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      logic [11:0] pc_hold;
      logic [15:0] acc_hold;
      // R1 reset state
      repeat (2) @(negedge clk);
      check("R1 reset pc", 32'(pc), 32'd0);
      check("R1 reset acc", 32'(acc), 32'd0);
      check("R1 reset zero", 32'(zero_flag), 32'd0);
      check("R1 reset halted", 32'(halted), 32'd0);
      check("R11 reset no write", 32'(mem_we), 32'd0);

      for (int k = 0; k < NV; k++) begin
         run_vec(k);
         if (k == 18) begin
            // R2 and R11: exactly one write, landing at 0x90
            check("R2 stored word", 32'(mem[8'h90]), 32'h1234);
            check("R11 single write", 32'(we_cnt), 32'd1);
            check("R11 neighbour untouched", 32'(mem[8'h91]), 32'h8000);
         end
      end

      // R9: halted state freezes everything
      pc_hold  = pc;
      acc_hold = acc;
      repeat (16) @(negedge clk);
      check("R9 still halted", 32'(halted), 32'd1);
      check("R9 pc frozen", 32'(pc), 32'(pc_hold));
      check("R9 acc frozen", 32'(acc), 32'(acc_hold));
      check("R9 no writes", 32'(we_cnt), 32'd0);

      // R1: reset after a run with nonzero state
      run_vec(0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rerun reset pc", 32'(pc), 32'd0);
      check("R1 rerun reset acc", 32'(acc), 32'd0);
      check("R1 rerun reset halted", 32'(halted), 32'd0);

      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

endmodule